// File: doc/BRIEF.md
# Dual Backup Cell Source Selector

This block decides which of two backup cells feeds the retention supply while main power is missing. One cell is a primary (non-rechargeable) cell, the other a rechargeable secondary cell. Both arrive as digitised voltage codes. A hysteresis code sets the margin that a voltage difference must exceed before the selection moves from one cell to the other. Two supply flags tell the block where the main supply sits: below the power-fail threshold, and below the switch-over level.

Cell comparison starts when the supply drops below the power-fail threshold. It keeps running until the supply climbs back above the switch-over level. The secondary cell is tried first. After that, the selection moves to whichever cell is higher, but only once the gap exceeds the margin.

Isolation stops the cells from draining when there is no data to keep. Two events set it: a cell being attached while the supply is grounded, and an isolation request pulse during power-down. Once set, it persists until the supply rises through the power-fail threshold.

Top module: `bkup_src_sel`

## Requirements
- R1: After reset, `src_sel_o` is 2'b00 and `iso_o` is 1.
- R2: In the clock cycle in which `below_so_i` is 0, the next edge drives `src_sel_o` to 2'b00, meaning no cell is selected and the main supply is in use.
- R3: A comparison window opens on the edge where `below_pfd_i` first reads 1 after reading 0. The first candidate is then the secondary cell. `src_sel_o` encodes the source as bit 0 for the secondary cell and bit 1 for the primary cell.
- R4: While the secondary cell is selected, the selection moves to the primary cell only when `sec_code_i + hyst_code_i < prim_code_i`, with the sum taken without overflow.
- R5: While the primary cell is selected, the selection moves back to the secondary cell only when `prim_code_i + hyst_code_i < sec_code_i`. Otherwise the current cell is kept.
- R6: A cell whose code is 0 is never selected. If exactly one code is nonzero, that cell is chosen regardless of hysteresis. If both codes are 0, `src_sel_o` is 2'b00.
- R7: A `cell_attach_i` pulse sampled while `below_so_i` is 1 sets isolation. The pulse is ignored while `below_so_i` is 0.
- R8: An `iso_req_i` pulse sampled while `below_pfd_i` is 1 sets isolation. The pulse is ignored while `below_pfd_i` is 0. While `iso_o` is 1, `src_sel_o` is 2'b00.
- R9: Isolation clears only on the edge where `below_pfd_i` reads 0 after reading 1. The next outage then selects a cell normally.
- R10: `src_sel_o` is registered, follows its inputs one clock later, and never has both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prim_code_i | input | CODE_W | Primary cell voltage code |
| sec_code_i | input | CODE_W | Secondary cell voltage code |
| hyst_code_i | input | CODE_W | Hysteresis margin code |
| below_pfd_i | input | 1 | Supply is below the power-fail threshold |
| below_so_i | input | 1 | Supply is below the switch-over level |
| cell_attach_i | input | 1 | A cell has just been connected |
| iso_req_i | input | 1 | Isolation request pulse |
| src_sel_o | output | 2 | One-hot source: bit 0 secondary, bit 1 primary, zero for none |
| iso_o | output | 1 | Cells isolated |

## Verification
The bench builds the block with CODE_W = 4. This makes every combination of primary, secondary and hysteresis code reachable: 4096 triples, each run through a full outage. For each triple the bench checks the first selection, a second step with the codes swapped, and the return to the main supply. This covers the strict-inequality edge of the hysteresis, overflow-free sums at full scale, and every zero-code case. Directed sequences then cover setting, holding and clearing isolation, including the cases where an attach or a request must be ignored.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic {
    CELL_SEC  = 1'b0,
    CELL_PRIM = 1'b1
  } cell_e;

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_SEC  = 2'b01;
  localparam logic [1:0] SEL_PRIM = 2'b10;
endpackage

// File: rtl/bss_supply_track.sv
module bss_supply_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_pfd_i,
  input  logic below_so_i,
  input  logic cell_attach_i,
  input  logic iso_req_i,
  output logic entry_o,
  output logic cmp_o,
  output logic out_en_o,
  output logic iso_o
);
  logic pfd_q, so_q, cmp_q, iso_q;
  logic so_rise, pfd_rise, cmp_n, iso_n;

  assign entry_o  = below_pfd_i && !pfd_q;
  assign so_rise  = so_q && !below_so_i;
  assign pfd_rise = pfd_q && !below_pfd_i;
  assign cmp_n    = below_pfd_i && (entry_o || (cmp_q && !so_rise));

  // set wins over clear; attach needs a grounded supply, request needs power-down
  always_comb begin
    iso_n = iso_q;
    if (pfd_rise) iso_n = 1'b0;
    if ((cell_attach_i && below_so_i) || (iso_req_i && below_pfd_i)) iso_n = 1'b1;
  end

  assign out_en_o = cmp_n && below_so_i && !iso_n;
  assign cmp_o    = cmp_q;
  assign iso_o    = iso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfd_q <= 1'b1;
      so_q  <= 1'b1;
      cmp_q <= 1'b0;
      iso_q <= 1'b1;
    end else begin
      pfd_q <= below_pfd_i;
      so_q  <= below_so_i;
      cmp_q <= cmp_n;
      iso_q <= iso_n;
    end
  end

  p_attach_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_attach_i && below_so_i) |=> iso_q);
  p_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_req_i && below_pfd_i) |=> iso_q);
  p_iso_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_q && below_pfd_i) |=> iso_q);
endmodule

// File: rtl/bss_cell_pick.sv
module bss_cell_pick #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] prim_code_i,
  input  logic [CODE_W-1:0] sec_code_i,
  input  logic [CODE_W-1:0] hyst_code_i,
  input  logic              entry_i,
  input  logic              cmp_i,
  input  logic              out_en_i,
  output logic [1:0]        sel_o
);
  import bss_pkg::*;
  localparam int SUM_W = CODE_W + 1;

  cell_e             cur_q, cur_n, start_cell;
  logic [SUM_W-1:0]  sec_plus, prim_plus;
  logic              prim_zero, sec_zero, go_prim, go_sec;
  logic [1:0]        sel_q, sel_n;

  assign prim_zero = (prim_code_i == '0);
  assign sec_zero  = (sec_code_i == '0);
  assign sec_plus  = SUM_W'(sec_code_i) + SUM_W'(hyst_code_i);
  assign prim_plus = SUM_W'(prim_code_i) + SUM_W'(hyst_code_i);
  assign go_prim   = sec_plus < SUM_W'(prim_code_i);
  assign go_sec    = prim_plus < SUM_W'(sec_code_i);
  assign start_cell = (sec_zero && !prim_zero) ? CELL_PRIM : CELL_SEC;

  always_comb begin
    cur_n = cur_q;
    if (entry_i) begin
      cur_n = start_cell;
    end else if (cmp_i) begin
      if (sec_zero && !prim_zero)      cur_n = CELL_PRIM;
      else if (prim_zero && !sec_zero) cur_n = CELL_SEC;
      else if (cur_q == CELL_SEC && go_prim) cur_n = CELL_PRIM;
      else if (cur_q == CELL_PRIM && go_sec) cur_n = CELL_SEC;
    end
  end

  always_comb begin
    sel_n = SEL_NONE;
    if (out_en_i) begin
      if (cur_n == CELL_SEC && !sec_zero)   sel_n = SEL_SEC;
      if (cur_n == CELL_PRIM && !prim_zero) sel_n = SEL_PRIM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= CELL_SEC;
      sel_q <= SEL_NONE;
    end else begin
      cur_q <= cur_n;
      sel_q <= sel_n;
    end
  end

  assign sel_o = sel_q;

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(sel_q));
  p_prim_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_zero |=> !sel_q[1]);
  p_sec_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_zero |=> !sel_q[0]);
  p_hold_sec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && !entry_i && cur_q == CELL_SEC && !sec_zero && !go_prim) |=> (cur_q == CELL_SEC));
endmodule

// File: rtl/bkup_src_sel.sv
module bkup_src_sel #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] prim_code_i,
  input  logic [CODE_W-1:0] sec_code_i,
  input  logic [CODE_W-1:0] hyst_code_i,
  input  logic              below_pfd_i,
  input  logic              below_so_i,
  input  logic              cell_attach_i,
  input  logic              iso_req_i,
  output logic [1:0]        src_sel_o,
  output logic              iso_o
);
  logic entry, cmp, out_en;

  bss_supply_track i_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .below_pfd_i  (below_pfd_i),
    .below_so_i   (below_so_i),
    .cell_attach_i(cell_attach_i),
    .iso_req_i    (iso_req_i),
    .entry_o      (entry),
    .cmp_o        (cmp),
    .out_en_o     (out_en),
    .iso_o        (iso_o)
  );

  bss_cell_pick #(.CODE_W(CODE_W)) i_pick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prim_code_i(prim_code_i),
    .sec_code_i (sec_code_i),
    .hyst_code_i(hyst_code_i),
    .entry_i    (entry),
    .cmp_i      (cmp),
    .out_en_i   (out_en),
    .sel_o      (src_sel_o)
  );

  p_main_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !below_so_i |=> (src_sel_o == 2'b00));
  p_iso_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_o |-> (src_sel_o == 2'b00));
endmodule

// File: tb/test_bkup_src_sel.sv
module test_bkup_src_sel;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] prim, sec, hyst;
  logic          bpfd, bso, attach, ireq;
  logic [1:0]    sel;
  logic          iso;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  bkup_src_sel #(.CODE_W(CW)) i_bkup_src_sel (
    .clk_i(clk), .rst_ni(rst_n), .prim_code_i(prim), .sec_code_i(sec),
    .hyst_code_i(hyst), .below_pfd_i(bpfd), .below_so_i(bso),
    .cell_attach_i(attach), .iso_req_i(ireq), .src_sel_o(sel), .iso_o(iso)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // model: 0 = secondary, 1 = primary
  function automatic bit nxt(bit cur, int p, int s, int h);
    if (s == 0 && p != 0) return 1'b1;
    if (p == 0 && s != 0) return 1'b0;
    if (!cur && (s + h < p)) return 1'b1;
    if (cur && (p + h < s)) return 1'b0;
    return cur;
  endfunction

  function automatic logic [1:0] enc(bit cur, int p, int s);
    if (cur && p != 0) return 2'b10;
    if (!cur && s != 0) return 2'b01;
    return 2'b00;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    prim = '0; sec = '0; hyst = '0;
    bpfd = 1'b1; bso = 1'b1; attach = 1'b0; ireq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sel", sel, 2'b00);
    chk("R1 iso", {1'b0, iso}, 2'b01);
    rst_n = 1'b1;
    step();
    // supply up: above switch-over, then above power-fail (clears isolation)
    bso = 1'b0; step();
    chk("R9 iso held below pfd", {1'b0, iso}, 2'b01);
    bpfd = 1'b0; step();
    chk("R9 iso cleared", {1'b0, iso}, 2'b00);

    for (int p = 0; p <= MAXC; p++) begin
      for (int s = 0; s <= MAXC; s++) begin
        for (int h = 0; h <= MAXC; h++) begin
          bit cur;
          string lab;
          prim = CW'(p); sec = CW'(s); hyst = CW'(h);
          bpfd = 1'b1; step();
          chk("R2 between thresholds", sel, 2'b00);
          cur = (s == 0 && p != 0);
          bso = 1'b1; step();
          cur = nxt(cur, p, s, h);
          lab = (p == 0 || s == 0) ? "R6 first pick" :
                (cur ? "R4 move to primary" : "R3 secondary first");
          chk(lab, sel, enc(cur, p, s));
          chk("R10 onehot", {1'b0, $countones(sel) > 1}, 2'b00);
          prim = CW'(s); sec = CW'(p);
          step();
          cur = nxt(cur, s, p, h);
          chk((p == 0 || s == 0) ? "R6 swapped" : "R5 alternate", sel, enc(cur, s, p));
          bso = 1'b0; step();
          chk("R2 back on main", sel, 2'b00);
          bpfd = 1'b0; step();
        end
      end
    end

    // ignored pulses while powered
    attach = 1'b1; step(); attach = 1'b0;
    chk("R7 attach ignored powered", {1'b0, iso}, 2'b00);
    ireq = 1'b1; step(); ireq = 1'b0;
    chk("R8 req ignored powered", {1'b0, iso}, 2'b00);

    // request during outage
    prim = 4'd9; sec = 4'd5; hyst = 4'd2;
    bpfd = 1'b1; step();
    bso = 1'b1; step();
    chk("R4 directed", sel, 2'b10);
    ireq = 1'b1; step(); ireq = 1'b0;
    chk("R8 iso set", {1'b0, iso}, 2'b01);
    chk("R8 sel none", sel, 2'b00);
    step();
    chk("R9 held in outage", {1'b0, iso}, 2'b01);
    chk("R9 sel held none", sel, 2'b00);
    bso = 1'b0; step();
    chk("R9 held above so", {1'b0, iso}, 2'b01);
    bpfd = 1'b0; step();
    chk("R9 cleared on pfd rise", {1'b0, iso}, 2'b00);
    bpfd = 1'b1; step();
    bso = 1'b1; step();
    chk("R9 next outage picks", sel, 2'b10);

    // attach while supply grounded
    attach = 1'b1; step(); attach = 1'b0;
    chk("R7 attach isolates", {1'b0, iso}, 2'b01);
    chk("R7 sel none", sel, 2'b00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule